// File: doc/BRIEF.md
# Paced Pulse Output FIFO

This block sits between a metering computation engine and the energy pulse pins. Once per multiplexer frame the engine produces a burst of six pulse-level updates for each of two channels, one for active energy and one for reactive energy. Each channel queues its burst and releases it to the pulse output one update at a time, spaced four times a programmable interval apart in fast-clock cycles. The pulse output therefore changes evenly across the frame instead of in a clump. An interval of zero turns the queue off, and each update then drives the output directly.

Each channel also limits the width of a low pulse. The pulse output is active low. When the applied updates keep it low for more than twice the max-width setting plus one updates in a row, the output is forced high. It stays high until a high update ends the pulse and a later low update starts a new one. A 2-bit select registers one of four sources onto an optical transmit output: plain serial data, the active pulse, the reactive pulse, or a constant idle high.

Top module: `pulse_pacer_top`

## Requirements
- R1: After reset both pulse outputs are high, both overflow flags are low, the optical output is high, and both queues are empty.
- R2: When the interval is zero, an update strobed on a clock edge appears on that channel's pulse output right after the same edge, and the queue holds nothing.
- R3: With a nonzero interval and the spacing timer expired, a queued update reaches the pulse output on the edge after the one that queued it.
- R4: With a nonzero interval, successive releases from a channel queue are exactly 4×interval clock cycles apart, in arrival order.
- R5: Each queue holds 8 updates. An update that arrives while the queue is full, with no release on the same edge, is dropped and sets that channel's overflow flag, which stays set until reset.
- R6: A low level applied more than 2×max_width+1 consecutive times drives the pulse output high (1). It stays high for any further low updates until a high update is applied.
- R7: The low-run count is cleared by every applied high update, so the next low update starts a new pulse and drives the output low (0).
- R8: The two channels are independent: strobes, queue state and overflow on one channel never change the other channel's outputs.
- R9: The optical output takes tx_sel 0 = tx_data, 1 = active pulse, 2 = reactive pulse, 3 = constant high, registered one clock after the selected source.
- R10: Frame sync clears the spacing timer, so a pending queued update is released on the edge after the frame sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | One-cycle start-of-frame marker |
| act_upd_vld | input | 1 | Active channel update strobe |
| act_upd_lvl | input | 1 | Active channel update level (0 = pulse low) |
| rct_upd_vld | input | 1 | Reactive channel update strobe |
| rct_upd_lvl | input | 1 | Reactive channel update level |
| interval | input | IVW | Release spacing, in units of 4 clocks; 0 bypasses the queue |
| max_width | input | MWW | Low-width limit setting |
| tx_sel | input | 2 | Optical output source select |
| tx_data | input | 1 | Serial data source for the optical output |
| act_pulse_n | output | 1 | Active energy pulse, active low |
| rct_pulse_n | output | 1 | Reactive energy pulse, active low |
| opt_tx | output | 1 | Optical transmit output |
| act_ovf | output | 1 | Active queue overflow, sticky |
| rct_ovf | output | 1 | Reactive queue overflow, sticky |

## Verification
A corrupted queue pointer or count shows at the pulse pin at the next release as a wrong level or a reordered burst. An overflow that fires too early or too late shows on the overflow flag within one cycle of the ninth update. A spacing timer loaded with the wrong value moves the second release of a burst off its 4×interval slot, so it is seen one release after the frame starts. A low-run counter that is wrong makes the forced-high edge appear one update early or late, or keeps the output from going low again after a high update.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_ACT = 0;
  localparam int CH_RCT = 1;

  typedef enum logic [1:0] {
    TX_SRC_DATA = 2'd0,
    TX_SRC_ACT  = 2'd1,
    TX_SRC_RCT  = 2'd2,
    TX_SRC_IDLE = 2'd3
  } tx_src_e;
endpackage

// File: rtl/pacer_fifo.sv
module pacer_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign do_push = push && (!full || pop);
  assign do_pop  = pop && !empty;
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign dout    = mem[rd_ptr];

  // storage has no reset so it maps onto a RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/pacer_timer.sv
module pacer_timer #(
  parameter int IVW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic           load,
  input  logic [IVW-1:0] interval,
  output logic           ready
);
  localparam int CW = IVW + 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;

  assign reload = {interval, 2'b00} - CW'(1);
  assign ready  = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || restart)   cnt_q <= '0;
    else if (load)        cnt_q <= reload;
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/pacer_limiter.sv
module pacer_limiter #(
  parameter int MWW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           apply,
  input  logic           lvl,
  input  logic [MWW-1:0] max_width,
  output logic           pulse_n
);
  localparam int CW = MWW + 2;

  logic [CW-1:0] run_q, run_inc, limit;

  assign limit   = CW'({max_width, 1'b1});
  // saturates one past the limit so the forced state holds
  assign run_inc = (run_q > limit) ? run_q : run_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      pulse_n <= 1'b1;
    end else if (apply) begin
      if (lvl) begin
        run_q   <= '0;
        pulse_n <= 1'b1;
      end else begin
        run_q   <= run_inc;
        pulse_n <= (run_inc > limit);
      end
    end
  end
endmodule

// File: rtl/pacer_channel.sv
module pacer_channel #(
  parameter int DEPTH = 8,
  parameter int IVW   = 8,
  parameter int MWW   = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_sync,
  input  logic           upd_vld,
  input  logic           upd_lvl,
  input  logic [IVW-1:0] interval,
  input  logic [MWW-1:0] max_width,
  output logic           pulse_n,
  output logic           ovf
);
  logic bypass, q_empty, q_full, q_dout, release_q, ready;
  logic apply, apply_lvl;

  assign bypass    = (interval == '0);
  assign release_q = ready && !q_empty && !bypass;
  assign apply     = bypass ? upd_vld : release_q;
  assign apply_lvl = bypass ? upd_lvl : q_dout;

  pacer_fifo #(.DEPTH(DEPTH), .WIDTH(1)) fifo_i (
    .clk   (clk),
    .rst   (rst),
    .flush (bypass),
    .push  (upd_vld && !bypass),
    .din   (upd_lvl),
    .pop   (release_q),
    .dout  (q_dout),
    .empty (q_empty),
    .full  (q_full)
  );

  pacer_timer #(.IVW(IVW)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .restart  (frame_sync),
    .load     (release_q),
    .interval (interval),
    .ready    (ready)
  );

  pacer_limiter #(.MWW(MWW)) lim_i (
    .clk       (clk),
    .rst       (rst),
    .apply     (apply),
    .lvl       (apply_lvl),
    .max_width (max_width),
    .pulse_n   (pulse_n)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (upd_vld && !bypass && q_full && !release_q) ovf <= 1'b1;
  end
endmodule

// File: rtl/pulse_pacer_top.sv
module pulse_pacer_top
  import pacer_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IVW   = 8,
  parameter int MWW   = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_sync,
  input  logic           act_upd_vld,
  input  logic           act_upd_lvl,
  input  logic           rct_upd_vld,
  input  logic           rct_upd_lvl,
  input  logic [IVW-1:0] interval,
  input  logic [MWW-1:0] max_width,
  input  logic [1:0]     tx_sel,
  input  logic           tx_data,
  output logic           act_pulse_n,
  output logic           rct_pulse_n,
  output logic           opt_tx,
  output logic           act_ovf,
  output logic           rct_ovf
);
  logic [NUM_CH-1:0] vld, lvl, pulse, ovf;

  assign vld[CH_ACT] = act_upd_vld;
  assign lvl[CH_ACT] = act_upd_lvl;
  assign vld[CH_RCT] = rct_upd_vld;
  assign lvl[CH_RCT] = rct_upd_lvl;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pacer_channel #(.DEPTH(DEPTH), .IVW(IVW), .MWW(MWW)) ch_i (
      .clk        (clk),
      .rst        (rst),
      .frame_sync (frame_sync),
      .upd_vld    (vld[c]),
      .upd_lvl    (lvl[c]),
      .interval   (interval),
      .max_width  (max_width),
      .pulse_n    (pulse[c]),
      .ovf        (ovf[c])
    );
  end

  assign act_pulse_n = pulse[CH_ACT];
  assign rct_pulse_n = pulse[CH_RCT];
  assign act_ovf     = ovf[CH_ACT];
  assign rct_ovf     = ovf[CH_RCT];

  always_ff @(posedge clk) begin
    if (rst) opt_tx <= 1'b1;
    else begin
      case (tx_src_e'(tx_sel))
        TX_SRC_DATA: opt_tx <= tx_data;
        TX_SRC_ACT:  opt_tx <= pulse[CH_ACT];
        TX_SRC_RCT:  opt_tx <= pulse[CH_RCT];
        default:     opt_tx <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker #(
  parameter int IVW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [IVW-1:0] interval,
  input logic           act_upd_vld,
  input logic           act_upd_lvl,
  input logic [1:0]     tx_sel,
  input logic           act_pulse_n,
  input logic           rct_pulse_n,
  input logic           opt_tx,
  input logic           act_ovf,
  input logic           rct_ovf
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs idle on the cycle after reset
  always @(posedge clk) begin
    if (rst_d === 1'b1)
      assert_reset_idle_R1: assert (act_pulse_n && rct_pulse_n && opt_tx && !act_ovf && !rct_ovf);
  end

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (act_ovf |=> act_ovf));

  assert_rct_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (rct_ovf |=> rct_ovf));

  assert_bypass_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ((interval == '0) && !act_upd_vld) |=> $stable(act_pulse_n));

  assert_bypass_high_R2: assert property (@(posedge clk) disable iff (rst)
    ((interval == '0) && act_upd_vld && act_upd_lvl) |=> act_pulse_n);

  assert_tx_act_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_sel == 2'd1) |=> (opt_tx == $past(act_pulse_n)));

  assert_tx_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_sel == 2'd3) |=> opt_tx);
endmodule

bind pulse_pacer_top pacer_checker #(.IVW(IVW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .interval    (interval),
  .act_upd_vld (act_upd_vld),
  .act_upd_lvl (act_upd_lvl),
  .tx_sel      (tx_sel),
  .act_pulse_n (act_pulse_n),
  .rct_pulse_n (rct_pulse_n),
  .opt_tx      (opt_tx),
  .act_ovf     (act_ovf),
  .rct_ovf     (rct_ovf)
);

// File: tb/pulse_pacer_top_tb_top.sv
`timescale 1ns/1ps
module pulse_pacer_top_tb_top;
  localparam int IVW = 8;
  localparam int MWW = 6;

  logic clk = 1'b0;
  logic rst, frame_sync, act_upd_vld, act_upd_lvl, rct_upd_vld, rct_upd_lvl;
  logic [IVW-1:0] interval;
  logic [MWW-1:0] max_width;
  logic [1:0] tx_sel;
  logic tx_data;
  logic act_pulse_n, rct_pulse_n, opt_tx, act_ovf, rct_ovf;

  int checks = 0;
  int errors = 0;

  // {level applied, expected act_pulse_n}, bypass mode, max_width = 1 (limit 3)
  localparam logic [1:0] LIM_VEC [12] = '{
    2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b11,
    2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b01
  };

  always #10 clk = ~clk;

  pulse_pacer_top #(.DEPTH(8), .IVW(IVW), .MWW(MWW)) dut_i (
    .clk(clk), .rst(rst), .frame_sync(frame_sync),
    .act_upd_vld(act_upd_vld), .act_upd_lvl(act_upd_lvl),
    .rct_upd_vld(rct_upd_vld), .rct_upd_lvl(rct_upd_lvl),
    .interval(interval), .max_width(max_width),
    .tx_sel(tx_sel), .tx_data(tx_data),
    .act_pulse_n(act_pulse_n), .rct_pulse_n(rct_pulse_n),
    .opt_tx(opt_tx), .act_ovf(act_ovf), .rct_ovf(rct_ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    frame_sync = 1'b0;
    act_upd_vld = 1'b0; act_upd_lvl = 1'b1;
    rct_upd_vld = 1'b0; rct_upd_lvl = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic push_act(input logic l);
    act_upd_vld = 1'b1; act_upd_lvl = l;
    step(1);
    act_upd_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    interval = '0; max_width = 6'd1; tx_sel = 2'd3; tx_data = 1'b0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check(act_pulse_n && rct_pulse_n, "R1 pulses idle", {act_pulse_n, rct_pulse_n}, 3);
    check(!act_ovf && !rct_ovf, "R1 overflow clear", {act_ovf, rct_ovf}, 0);
    check(opt_tx == 1'b1, "R1 optical idle", opt_tx, 1);

    // R2 R6 R7 R8: limiter table in bypass mode
    foreach (LIM_VEC[i]) begin
      push_act(LIM_VEC[i][1]);
      check(act_pulse_n == LIM_VEC[i][0], $sformatf("R2/R6/R7 vector %0d", i),
            act_pulse_n, LIM_VEC[i][0]);
    end
    check(rct_pulse_n == 1'b1, "R8 reactive untouched", rct_pulse_n, 1);

    // R8 reactive channel alone
    rct_upd_vld = 1'b1; rct_upd_lvl = 1'b0;
    step(1);
    rct_upd_vld = 1'b0;
    check(rct_pulse_n == 1'b0, "R8 reactive low", rct_pulse_n, 0);
    check(act_pulse_n == 1'b1, "R8 active unchanged", act_pulse_n, 1);

    // R9 optical select
    tx_sel = 2'd0; tx_data = 1'b0; step(1);
    check(opt_tx == 1'b0, "R9 data 0", opt_tx, 0);
    tx_data = 1'b1; step(1);
    check(opt_tx == 1'b1, "R9 data 1", opt_tx, 1);
    tx_sel = 2'd2; step(1);
    check(opt_tx == 1'b0, "R9 reactive src", opt_tx, 0);
    tx_sel = 2'd1; step(1);
    check(opt_tx == 1'b1, "R9 active src", opt_tx, 1);
    tx_sel = 2'd3;

    // R3 R4: paced burst, interval 2 -> spacing 8
    do_reset();
    interval = 8'd2; max_width = 6'd20;
    frame_sync = 1'b1; step(1); frame_sync = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      act_upd_vld = 1'b1; act_upd_lvl = (i % 2 == 0);
      step(1);
      if (i == 1) check(act_pulse_n == 1'b1, "R3 not before next edge", act_pulse_n, 1);
      if (i == 2) check(act_pulse_n == 1'b0, "R3 first release", act_pulse_n, 0);
    end
    act_upd_vld = 1'b0;
    step(3);
    check(act_pulse_n == 1'b0, "R4 held before slot", act_pulse_n, 0);
    step(1);
    check(act_pulse_n == 1'b1, "R4 second release", act_pulse_n, 1);
    step(7);
    check(act_pulse_n == 1'b1, "R4 held before third", act_pulse_n, 1);
    step(1);
    check(act_pulse_n == 1'b0, "R4 third release", act_pulse_n, 0);

    // R5 overflow, interval 3
    do_reset();
    interval = 8'd3;
    act_upd_lvl = 1'b1;
    act_upd_vld = 1'b1;
    step(9);
    check(act_ovf == 1'b0, "R5 no overflow at 8 held", act_ovf, 0);
    step(1);
    act_upd_vld = 1'b0;
    check(act_ovf == 1'b1, "R5 overflow on drop", act_ovf, 1);
    check(rct_ovf == 1'b0, "R8 reactive overflow clear", rct_ovf, 0);
    step(30);
    check(act_ovf == 1'b1, "R5 overflow sticky", act_ovf, 1);

    // R10 frame sync restart
    do_reset();
    interval = 8'd3;
    push_act(1'b0);
    check(act_pulse_n == 1'b1, "R10 before release", act_pulse_n, 1);
    step(1);
    check(act_pulse_n == 1'b0, "R10 first release", act_pulse_n, 0);
    push_act(1'b1);
    frame_sync = 1'b1; step(1); frame_sync = 1'b0;
    check(act_pulse_n == 1'b0, "R10 pending at sync edge", act_pulse_n, 0);
    step(1);
    check(act_pulse_n == 1'b1, "R10 released after sync", act_pulse_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule